// File: doc/BRIEF.md
# Configurable SPI Master/Slave Transceiver

This block moves one byte at a time over a four-wire serial link and can act as either end of it. A single 8-bit setup register, writable only while the block is disabled, picks the role (master or slave), the serial clock rate a master generates, whether the pin inputs are re-timed through two flops or used raw, where the slave-select level comes from, and which event drives the interrupt line.

As master, a byte written to the transmit register moves into the shift register on the next idle cycle, and the block runs eight clock periods. It presents each bit most significant first while the serial clock is low and captures the returning bit at the end of each high phase. As slave, the block shifts on the edges of the incoming clock while its effective select is low. It captures on each rising edge and presents the next bit after each falling edge. In both roles the received byte lands in a receive register and raises a completion flag that a read clears.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the setup register reads 0x00, `irq`, `rx_done` and `sclk_o` are 0 and `tx_empty` is 1.
- R2: A setup write while `enable` is low replaces the register. Its fields are: bits 7:5 rate code, bit 4 raw inputs, bit 3 forced select level, bit 2 select source (0 = bit 3, 1 = pin), bit 1 interrupt source, bit 0 role (0 = master, 1 = slave). A setup write while `enable` is high is ignored.
- R3: In master mode each half period of `sclk_o` lasts 2^code system clocks, for rate codes 0 to 7. A byte written to the transmit register in cycle 0 sets `rx_done` 16·2^code + 1 cycles later.
- R4: Master and slave exchange one 8-bit byte per transfer, MSB first, with the clock idling low. Each side receives the byte the other side sent.
- R5: With bit 4 = 0 every pin input passes through two flops; with bit 4 = 1 the pins are used directly. A slave therefore acts on an incoming clock edge 1 cycle after it reaches the pin with bit 4 set, and 3 cycles after it with bit 4 clear.
- R6: With bit 2 = 0 the slave is selected when bit 3 is 0 and ignores the bus when bit 3 is 1, whatever the select pin does. With bit 2 = 1 the select pin (low = selected) decides.
- R7: A slave counts bits only while selected. If the select goes inactive mid-byte the bit count restarts and no completion is flagged for the partial byte.
- R8: `rx_done` sets when the eighth bit is captured into `rx_data` and clears in the cycle after an `rx_re` pulse, unless a new byte completes in that same cycle.
- R9: `irq` is `tx_empty` when bit 1 = 0 and `rx_done` when bit 1 = 1, and it is held at 0 while `enable` is low.
- R10: A transmit write clears `tx_empty` in the next cycle. In master mode, when the block is idle, the byte moves into the shift register one cycle later and `tx_empty` sets again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Block enable; freezes the setup register |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_wdata | input | 8 | Setup register write data |
| cfg_rdata | output | 8 | Setup register contents |
| tx_we | input | 1 | Transmit register write strobe |
| tx_wdata | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit register can take a byte |
| rx_re | input | 1 | Receive register read strobe, clears `rx_done` |
| rx_data | output | 8 | Last complete received byte |
| rx_done | output | 1 | Transfer-complete flag |
| sclk_i | input | 1 | Serial clock from the bus (slave) |
| mosi_i | input | 1 | Master-to-slave data from the bus (slave) |
| miso_i | input | 1 | Slave-to-master data from the bus (master) |
| ss_n_i | input | 1 | Slave select pin, active low |
| sclk_o | output | 1 | Generated serial clock (master) |
| mosi_o | output | 1 | Master-to-slave data driven (master) |
| miso_o | output | 1 | Slave-to-master data driven (selected slave) |
| irq | output | 1 | Interrupt |

## Verification
A master instance is looped into a slave instance at every rate code. The bench counts cycles to both completion flags, so a divider off by one period, or a synchronizer added or dropped, shows up as a wrong cycle count even when the bytes still arrive. At codes 0 and 1 it uses raw inputs, where a sampling point placed too early would capture the previous bit. A slave that kept counting edges while deselected, or that kept its bit count across a mid-byte abort, would report a completion for the partial byte, or it would misalign the next full byte. The bench also checks that a setup write during operation leaves the register unchanged, and it follows the interrupt through the one-cycle dip in `tx_empty` in the other interrupt mode.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  // Width of the rate code field in the setup register.
  localparam int SEL_W = 3;

  // Setup register layout, MSB first: rate, raw inputs, forced select level,
  // select from pin, interrupt on completion, slave role.
  typedef struct packed {
    logic [SEL_W-1:0] rate;
    logic             raw_in;
    logic             ss_lvl;
    logic             ss_from_pin;
    logic             irq_on_done;
    logic             is_slave;
  } cfg_t;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int             W       = 4,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bypass,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic st1_q;
    logic st2_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1_q <= RST_VAL[g];
        st2_q <= RST_VAL[g];
      end else begin
        st1_q <= pin_i[g];
        st2_q <= st1_q;
      end
    end

    assign pin_o[g] = bypass ? pin_i[g] : st2_q;
  end

endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int MAX_SEL = (1 << SEL_W) - 1;
  localparam int CNT_W   = (MAX_SEL < 1) ? 1 : MAX_SEL;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_cnt;

  // Half period is 2^sel cycles, so the terminal count is 2^sel - 1.
  assign last_cnt = {CNT_W{1'b1}} >> (MAX_SEL - int'(sel));
  assign tick     = run && (cnt_q == last_cnt);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  cfg_t              cfg,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_re,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              miso_s,
  input  logic              ss_eff_n,
  input  logic              tick,
  output logic              run,
  output logic              cmp_pulse,
  output logic              tx_empty,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              miso_o
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] txb_q,  txb_d;
  logic              full_q, full_d;
  logic [DATA_W-1:0] sh_q,   sh_d;
  logic [CNT_W-1:0]  bit_q,  bit_d;
  logic              busy_q, busy_d;
  logic              clk_q,  clk_d;
  logic              prev_q;
  logic              cap_q,  cap_d;
  logic [DATA_W-1:0] rx_q,   rx_d;
  logic              done_q, done_d;
  logic              cmp;
  logic              s_rise;
  logic              s_fall;

  assign s_rise = sclk_s & ~prev_q;
  assign s_fall = ~sclk_s & prev_q;

  always_comb begin
    txb_d  = txb_q;
    full_d = full_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    clk_d  = clk_q;
    cap_d  = cap_q;
    rx_d   = rx_q;
    cmp    = 1'b0;

    if (!cfg.is_slave) begin
      // Master: load when idle, toggle the clock on each half-period tick,
      // capture at the end of each high phase.
      if (!busy_q) begin
        if (enable && full_q) begin
          sh_d   = txb_q;
          full_d = 1'b0;
          busy_d = 1'b1;
          bit_d  = '0;
          clk_d  = 1'b0;
        end
      end else if (tick) begin
        if (!clk_q) begin
          clk_d = 1'b1;
        end else begin
          clk_d = 1'b0;
          sh_d  = {sh_q[DATA_W-2:0], miso_s};
          if (bit_q == LAST_BIT) begin
            cmp    = 1'b1;
            rx_d   = {sh_q[DATA_W-2:0], miso_s};
            busy_d = 1'b0;
            bit_d  = '0;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
    end else begin
      // Slave: follow the bus clock only while enabled and selected.
      if (!enable || ss_eff_n) begin
        bit_d = '0;
      end else if (s_rise) begin
        if (bit_q == LAST_BIT) begin
          cmp   = 1'b1;
          rx_d  = {sh_q[DATA_W-2:0], mosi_s};
          bit_d = '0;
        end else begin
          cap_d = mosi_s;
          bit_d = bit_q + 1'b1;
        end
      end else if (s_fall && (bit_q != '0)) begin
        sh_d = {sh_q[DATA_W-2:0], cap_q};
      end
      if (enable && (bit_q == '0) && full_q) begin
        sh_d   = txb_q;
        full_d = 1'b0;
      end
    end

    if (tx_we) begin
      txb_d  = tx_wdata;
      full_d = 1'b1;
    end
  end

  always_comb begin
    done_d = done_q;
    if (cmp) begin
      done_d = 1'b1;
    end else if (rx_re) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_q  <= '0;
      full_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      clk_q  <= 1'b0;
      prev_q <= 1'b0;
      cap_q  <= 1'b0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      txb_q  <= txb_d;
      full_q <= full_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
      clk_q  <= clk_d;
      prev_q <= sclk_s;
      cap_q  <= cap_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign run       = busy_q & ~cfg.is_slave;
  assign cmp_pulse = cmp;
  assign tx_empty  = ~full_q;
  assign rx_data   = rx_q;
  assign rx_done   = done_q;
  assign sclk_o    = clk_q & ~cfg.is_slave;
  assign mosi_o    = cfg.is_slave ? 1'b0 : sh_q[DATA_W-1];
  assign miso_o    = (cfg.is_slave && !ss_eff_n) ? sh_q[DATA_W-1] : 1'b0;

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic              tx_empty,
  input  logic              rx_re,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              miso_i,
  input  logic              ss_n_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              miso_o,
  output logic              irq
);

  logic       rs1_q;
  logic       rst_sync_n;
  cfg_t       cfg_q;
  cfg_t       cfg_d;
  logic [3:0] pins_s;
  logic       sclk_s;
  logic       mosi_s;
  logic       miso_s;
  logic       ss_s;
  logic       ss_eff_n;
  logic       run;
  logic       tick;
  logic       cmp_pulse;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs1_q      <= 1'b1;
      rst_sync_n <= rs1_q;
    end
  end

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we && !enable) begin
      cfg_d = cfg_t'(cfg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  spi_in_sync #(
    .W       (4),
    .RST_VAL (4'b0001)
  ) i_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .bypass (cfg_q.raw_in),
    .pin_i  ({sclk_i, mosi_i, miso_i, ss_n_i}),
    .pin_o  (pins_s)
  );

  assign {sclk_s, mosi_s, miso_s, ss_s} = pins_s;
  assign ss_eff_n = cfg_q.ss_from_pin ? ss_s : cfg_q.ss_lvl;

  spi_baud #(
    .SEL_W (SEL_W)
  ) i_baud (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .sel   (cfg_q.rate),
    .tick  (tick)
  );

  spi_shift_core #(
    .DATA_W (DATA_W)
  ) i_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (enable),
    .cfg       (cfg_q),
    .tx_we     (tx_we),
    .tx_wdata  (tx_wdata),
    .rx_re     (rx_re),
    .sclk_s    (sclk_s),
    .mosi_s    (mosi_s),
    .miso_s    (miso_s),
    .ss_eff_n  (ss_eff_n),
    .tick      (tick),
    .run       (run),
    .cmp_pulse (cmp_pulse),
    .tx_empty  (tx_empty),
    .rx_data   (rx_data),
    .rx_done   (rx_done),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .miso_o    (miso_o)
  );

  assign cfg_rdata = cfg_q;
  assign irq       = enable & (cfg_q.irq_on_done ? rx_done : tx_empty);

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       cfg_we,
  input logic [7:0] cfg_q,
  input logic       tx_we,
  input logic       tx_empty,
  input logic       rx_re,
  input logic       rx_done,
  input logic       cmp_pulse,
  input logic       sclk_o
);

  logic [8:0] high_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_len <= '0;
    end else if (sclk_o) begin
      high_len <= high_len + 1'b1;
    end else begin
      high_len <= '0;
    end
  end

  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cfg_we) |=> (cfg_q == $past(cfg_q)));

  p_high_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (high_len == (9'd1 << cfg_q[7:5])));

  p_done_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> rx_done);

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_re && !cmp_pulse) |=> !rx_done);

  p_write_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |=> !tx_empty);

endmodule

bind spi_xcvr spi_xcvr_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .enable    (enable),
  .cfg_we    (cfg_we),
  .cfg_q     (cfg_rdata),
  .tx_we     (tx_we),
  .tx_empty  (tx_empty),
  .rx_re     (rx_re),
  .rx_done   (rx_done),
  .cmp_pulse (cmp_pulse),
  .sclk_o    (sclk_o)
);

// File: tb/test_spi_xcvr.sv
module test_spi_xcvr;

  logic clk;
  logic rst_n;
  logic en;

  logic       m_cfg_we, s_cfg_we;
  logic [7:0] m_cfg_d,  s_cfg_d;
  logic [7:0] m_cfg_q,  s_cfg_q;
  logic       m_tx_we,  s_tx_we;
  logic [7:0] m_tx_d,   s_tx_d;
  logic       m_empty,  s_empty;
  logic       m_rd,     s_rd;
  logic [7:0] m_rx,     s_rx;
  logic       m_done,   s_done;
  logic       m_sclk, m_mosi, m_miso_unused;
  logic       s_sclk_unused, s_mosi_unused, s_miso;
  logic       m_irq, s_irq;
  logic       ss_pin;

  int n_chk;
  int n_err;
  logic finished;

  // {rate code, raw inputs, master byte, slave byte}
  localparam logic [19:0] VEC [8] = '{
    {3'd0, 1'b1, 8'hA5, 8'h5A},
    {3'd1, 1'b1, 8'h3C, 8'hC3},
    {3'd2, 1'b0, 8'h01, 8'h80},
    {3'd3, 1'b0, 8'hFF, 8'h00},
    {3'd4, 1'b0, 8'h96, 8'h69},
    {3'd5, 1'b0, 8'h7E, 8'h81},
    {3'd6, 1'b0, 8'h55, 8'hAA},
    {3'd7, 1'b1, 8'hE1, 8'h1E}
  };

  spi_xcvr i_spi_xcvr (
    .clk(clk), .rst_n(rst_n), .enable(en),
    .cfg_we(m_cfg_we), .cfg_wdata(m_cfg_d), .cfg_rdata(m_cfg_q),
    .tx_we(m_tx_we), .tx_wdata(m_tx_d), .tx_empty(m_empty),
    .rx_re(m_rd), .rx_data(m_rx), .rx_done(m_done),
    .sclk_i(1'b0), .mosi_i(1'b0), .miso_i(s_miso), .ss_n_i(1'b1),
    .sclk_o(m_sclk), .mosi_o(m_mosi), .miso_o(m_miso_unused), .irq(m_irq)
  );

  spi_xcvr i_spi_xcvr_slv (
    .clk(clk), .rst_n(rst_n), .enable(en),
    .cfg_we(s_cfg_we), .cfg_wdata(s_cfg_d), .cfg_rdata(s_cfg_q),
    .tx_we(s_tx_we), .tx_wdata(s_tx_d), .tx_empty(s_empty),
    .rx_re(s_rd), .rx_data(s_rx), .rx_done(s_done),
    .sclk_i(m_sclk), .mosi_i(m_mosi), .miso_i(1'b0), .ss_n_i(ss_pin),
    .sclk_o(s_sclk_unused), .mosi_o(s_mosi_unused), .miso_o(s_miso), .irq(s_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    en = v;
  endtask

  task automatic wr_cfg(input logic [7:0] mv, input logic [7:0] sv);
    @(negedge clk);
    m_cfg_we = 1'b1; m_cfg_d = mv;
    s_cfg_we = 1'b1; s_cfg_d = sv;
    @(negedge clk);
    m_cfg_we = 1'b0; s_cfg_we = 1'b0;
  endtask

  task automatic wr_slave_tx(input logic [7:0] v);
    @(negedge clk);
    s_tx_we = 1'b1; s_tx_d = v;
    @(negedge clk);
    s_tx_we = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_both();
    @(negedge clk);
    m_rd = 1'b1; s_rd = 1'b1;
    @(negedge clk);
    m_rd = 1'b0; s_rd = 1'b0;
  endtask

  // Write the master byte in cycle 0 and count edges until the flags show.
  task automatic xfer(input logic [7:0] mtx, input logic probe, output int mcnt, output int scnt);
    @(negedge clk);
    m_tx_we = 1'b1; m_tx_d = mtx;
    @(posedge clk);
    #1;
    if (probe) begin
      chk(m_empty == 1'b0, "R10 empty clears on write", 32'(m_empty), 0);
      chk(m_irq == 1'b0, "R9 irq follows tx_empty low", 32'(m_irq), 0);
    end
    @(negedge clk);
    m_tx_we = 1'b0;
    mcnt = 0;
    scnt = 0;
    for (int k = 1; k <= 5000; k++) begin
      @(posedge clk);
      #1;
      if (probe && k == 1) begin
        chk(m_empty == 1'b1, "R10 empty sets on load", 32'(m_empty), 1);
        chk(m_irq == 1'b1, "R9 irq follows tx_empty high", 32'(m_irq), 1);
      end
      if (scnt == 0 && s_done) scnt = k;
      if (mcnt == 0 && m_done) mcnt = k;
      if (mcnt != 0) break;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    int mc, sc, half, exp_s;
    logic [7:0] keep;
    n_chk = 0; n_err = 0; finished = 1'b0;
    rst_n = 1'b0; en = 1'b0; ss_pin = 1'b1;
    m_cfg_we = 0; s_cfg_we = 0; m_cfg_d = 0; s_cfg_d = 0;
    m_tx_we = 0; s_tx_we = 0; m_tx_d = 0; s_tx_d = 0;
    m_rd = 0; s_rd = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(m_cfg_q == 8'h00, "R1 cfg reset", 32'(m_cfg_q), 0);
    chk(m_irq == 1'b0 && m_done == 1'b0, "R1 irq/done reset", {m_irq, m_done}, 0);
    chk(m_empty == 1'b1 && m_sclk == 1'b0, "R1 empty/sclk reset", {m_empty, m_sclk}, 2);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table: master looped into slave at each rate code.
    for (int i = 0; i < 8; i++) begin
      logic [2:0] sel;
      logic       byp;
      logic [7:0] mtx, stx;
      {sel, byp, mtx, stx} = VEC[i];
      half = 1 << sel;
      set_en(1'b0);
      wr_cfg({sel, byp, 1'b0, 1'b0, 1'b1, 1'b0}, {sel, byp, 1'b0, 1'b0, 1'b1, 1'b1});
      chk(m_cfg_q == {sel, byp, 4'b0010}, "R2 cfg write while disabled", 32'(m_cfg_q), 32'({sel, byp, 4'b0010}));
      set_en(1'b1);
      wr_slave_tx(stx);
      xfer(mtx, 1'b0, mc, sc);
      chk(mc == 1 + 16 * half, "R3 master byte duration", 32'(mc), 32'(1 + 16 * half));
      exp_s = mc - half + 1 + (byp ? 0 : 2);
      chk(sc == exp_s, "R5 slave completion latency", 32'(sc), 32'(exp_s));
      chk(m_rx == stx, "R4 master received byte", 32'(m_rx), 32'(stx));
      chk(s_rx == mtx, "R4 slave received byte", 32'(s_rx), 32'(mtx));
      chk(s_irq == 1'b1 && m_irq == 1'b1, "R9 irq on completion", {m_irq, s_irq}, 3);
      rd_both();
      #1;
      chk(m_done == 1'b0 && s_done == 1'b0, "R8 read clears done", {m_done, s_done}, 0);
    end

    // R2: setup writes ignored while enabled.
    keep = m_cfg_q;
    @(negedge clk);
    m_cfg_we = 1'b1; m_cfg_d = 8'hFF;
    @(negedge clk);
    m_cfg_we = 1'b0;
    chk(m_cfg_q == keep, "R2 cfg write ignored while enabled", 32'(m_cfg_q), 32'(keep));

    // R9/R10: interrupt on transmit empty.
    set_en(1'b0);
    chk(m_irq == 1'b0, "R9 irq low while disabled", 32'(m_irq), 0);
    wr_cfg({3'd2, 1'b0, 4'b0000}, {3'd2, 1'b0, 4'b0011});
    set_en(1'b1);
    @(negedge clk);
    chk(m_irq == 1'b1, "R9 irq on tx empty", 32'(m_irq), 1);
    wr_slave_tx(8'h42);
    xfer(8'h24, 1'b1, mc, sc);
    chk(s_rx == 8'h24 && m_rx == 8'h42, "R4 exchange in empty-irq mode", {s_rx, m_rx}, 16'h2442);
    rd_both();

    // R6: forced deselect ignores the bus.
    keep = s_rx;
    set_en(1'b0);
    wr_cfg({3'd2, 1'b0, 4'b0010}, {3'd2, 1'b0, 4'b1011});
    set_en(1'b1);
    wr_slave_tx(8'h77);
    ss_pin = 1'b0;
    xfer(8'h99, 1'b0, mc, sc);
    chk(s_done == 1'b0 && s_rx == keep, "R6 forced deselect ignores bus", {s_done, s_rx}, {1'b0, keep});
    rd_both();

    // R6: select from pin.
    set_en(1'b0);
    wr_cfg({3'd2, 1'b0, 4'b0010}, {3'd2, 1'b0, 4'b0111});
    set_en(1'b1);
    ss_pin = 1'b1;
    wr_slave_tx(8'h5A);
    xfer(8'h18, 1'b0, mc, sc);
    chk(s_done == 1'b0 && s_rx == keep, "R6 pin high deselects", {s_done, s_rx}, {1'b0, keep});
    rd_both();
    ss_pin = 1'b0;
    wr_slave_tx(8'h5A);
    xfer(8'hC3, 1'b0, mc, sc);
    chk(s_rx == 8'hC3 && m_rx == 8'h5A, "R6 pin low selects", {s_rx, m_rx}, 16'hC35A);
    rd_both();

    // R7: mid-byte deselect drops the partial byte.
    set_en(1'b0);
    wr_cfg({3'd3, 1'b0, 4'b0010}, {3'd3, 1'b0, 4'b0111});
    set_en(1'b1);
    wr_slave_tx(8'h11);
    @(negedge clk);
    m_tx_we = 1'b1; m_tx_d = 8'h96;
    @(negedge clk);
    m_tx_we = 1'b0;
    repeat (50) @(negedge clk);
    ss_pin = 1'b1;
    repeat (120) @(negedge clk);
    chk(m_done == 1'b1, "R7 master finished aborted byte", 32'(m_done), 1);
    chk(s_done == 1'b0, "R7 no completion for partial byte", 32'(s_done), 0);
    rd_both();
    ss_pin = 1'b0;
    wr_slave_tx(8'h3C);
    xfer(8'hA5, 1'b0, mc, sc);
    chk(s_done == 1'b1 && s_rx == 8'hA5, "R7 slave realigned after abort", {s_done, s_rx}, 9'h1A5);
    chk(m_rx == 8'h3C, "R7 master byte after abort", 32'(m_rx), 32'h3C);
    rd_both();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule